// File: doc/BRIEF.md
# MMU Translation Mode Selector

This block sits in front of a translation lookaside buffer. For each access request it decides how the virtual address is to be handled. There are three outcomes. In bypass, the physical address is the virtual address cut down to the implemented physical width. In real translation, the lookup uses context zero and carries the partition tag. In virtual translation, the lookup uses a context taken from processor state.

Processor state arrives as one packed word. From that word, an address-space class code and a path select (instruction fetch or data access), the block produces the translation mode, the context value and context kind for the lookup, the partition ID, the bypass physical address and an illegal-access fault. One decision is registered per accepted request, one cycle after it.

Top module: `mmu_mode_sel`

## Requirements
- R1: A response (`rsp_valid` high) appears in the cycle after each cycle with `req_valid` high, and carries that request's decision. After a cycle without a request, `rsp_valid` is low and the decision outputs keep their values. After reset, all outputs are zero.
- R2: State word fields are read from these bits: hypervisor privilege at bit 0, recovery (RED) state at bit 1, instruction MMU enable at bit 4, data MMU enable at bit 5, partition ID at bits 15:8, trap level at bits 18:16 and primary context at bits 47:32. The partition ID is presented on every response.
- R3: The access-class code is 0 implicit, 1 primary, 2 secondary, 3 nucleus and 4 real. Codes 5 to 7 on either path raise `rsp_fault`. On the instruction path, any code other than implicit also raises `rsp_fault`. A faulting response has mode, kind, context and physical address all zero.
- R4: On the instruction path, when hypervisor privilege or recovery state is set, the mode is bypass (mode code 2). The physical address is then the low PA_W bits of the virtual address, the context is 0 and the kind is primary.
- R5: On the instruction path without bypass, a nonzero trap level gives kind nucleus (code 2) with context 0. A zero trap level gives kind primary (code 0) with the primary context.
- R6: On the instruction path without bypass, a clear instruction MMU enable gives real mode (code 1) with context 0, and the kind from R5 is kept. Otherwise the mode is virtual (code 0).
- R7: On the data path, the mode is bypass in two cases: recovery state is set, or hypervisor privilege is set and the class is not real. Bypass gives context 0, kind primary and the masked address.
- R8: On the data path without bypass, a nonzero trap level or the nucleus class gives kind nucleus with context 0. This takes priority over the secondary class.
- R9: On the data path without bypass or nucleus, the secondary class gives kind secondary (code 1) with the `sec_ctx` input. The implicit and primary classes give kind primary with the primary context.
- R10: On the data path without bypass, the mode is real with context 0 when the data MMU enable is clear or the class is real. The kind from R8/R9 is kept. Otherwise the mode is virtual.
- R11: `rsp_paddr` is zero in every response whose mode is not bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_data | input | 1 | 1 selects the data path, 0 the instruction path |
| req_asi | input | 3 | Access-class code |
| state_word | input | SW_W | Packed processor state |
| sec_ctx | input | CTX_W | Secondary context value |
| vaddr | input | VA_W | Virtual address |
| rsp_valid | output | 1 | Decision present |
| rsp_fault | output | 1 | Illegal access class |
| rsp_mode | output | 2 | 0 virtual, 1 real, 2 bypass |
| rsp_kind | output | 2 | 0 primary, 1 secondary, 2 nucleus |
| rsp_ctx | output | CTX_W | Context for the lookup |
| rsp_part | output | PART_W | Partition ID |
| rsp_paddr | output | PA_W | Bypass physical address |

## Verification
The bench sweeps both paths against all eight class codes, every combination of the hypervisor, recovery and two MMU-enable bits, and four trap levels. This pulls apart the precedence chain: fault before bypass, bypass before context choice, and nucleus before secondary. Real mode is shown to keep the context kind while zeroing the value. The primary and secondary contexts, the partition and the address change from vector to vector, so a swapped field or a wrong bit slice gives a visible miscompare. A trailing idle cycle shows that the decision holds when no request arrives.

// File: rtl/mmu_ms_pkg.sv
package mmu_ms_pkg;
    parameter int CTX_W  = 16;
    parameter int PART_W = 8;
    parameter int TL_W   = 3;

    // field positions inside the packed state word
    localparam int B_HPRIV  = 0;
    localparam int B_RED    = 1;
    localparam int B_IMMU   = 4;
    localparam int B_DMMU   = 5;
    localparam int PART_LO  = 8;
    localparam int TL_LO    = 16;
    localparam int PCTX_LO  = 32;
    localparam int SW_MIN_W = PCTX_LO + CTX_W;

    // access-class codes
    localparam logic [2:0] AC_IMPL = 3'd0;
    localparam logic [2:0] AC_PRI  = 3'd1;
    localparam logic [2:0] AC_SEC  = 3'd2;
    localparam logic [2:0] AC_NUC  = 3'd3;
    localparam logic [2:0] AC_REAL = 3'd4;

    typedef enum logic [1:0] {XM_VIRT = 2'd0, XM_REAL = 2'd1, XM_BYPASS = 2'd2} xmode_e;
    typedef enum logic [1:0] {CK_PRI = 2'd0, CK_SEC = 2'd1, CK_NUC = 2'd2} ckind_e;

    typedef struct packed {
        logic              hpriv;
        logic              red;
        logic              immu_en;
        logic              dmmu_en;
        logic [PART_W-1:0] part;
        logic [TL_W-1:0]   tl;
        logic [CTX_W-1:0]  pctx;
    } pstate_t;

    typedef struct packed {
        logic             fault;
        xmode_e           mode;
        ckind_e           kind;
        logic [CTX_W-1:0] ctx;
    } decision_t;
endpackage

// File: rtl/mmu_ms_unpack.sv
module mmu_ms_unpack
    import mmu_ms_pkg::*;
#(
    parameter int SW_W = 64
) (
    input  logic [SW_W-1:0] state_word,
    output pstate_t         st
);
    logic unused_sw_bits;
    assign unused_sw_bits = ^{state_word[3:2], state_word[7:6], state_word[31:19],
                              state_word[SW_W-1:SW_MIN_W]};

    always_comb begin
        st.hpriv   = state_word[B_HPRIV];
        st.red     = state_word[B_RED];
        st.immu_en = state_word[B_IMMU];
        st.dmmu_en = state_word[B_DMMU];
        st.part    = state_word[PART_LO +: PART_W];
        st.tl      = state_word[TL_LO +: TL_W];
        st.pctx    = state_word[PCTX_LO +: CTX_W];
    end
endmodule

// File: rtl/mmu_ms_ipath.sv
module mmu_ms_ipath
    import mmu_ms_pkg::*;
(
    input  pstate_t   st,
    input  logic [2:0] asi,
    output decision_t dec
);
    always_comb begin
        dec = '0;
        if (asi != AC_IMPL) begin
            dec.fault = 1'b1;
        end else if (st.hpriv || st.red) begin
            dec.mode = XM_BYPASS;
        end else begin
            if (st.tl != '0) begin
                dec.kind = CK_NUC;
                dec.ctx  = '0;
            end else begin
                dec.kind = CK_PRI;
                dec.ctx  = st.pctx;
            end
            if (!st.immu_en) begin
                dec.mode = XM_REAL;
                dec.ctx  = '0;
            end else begin
                dec.mode = XM_VIRT;
            end
        end
    end
endmodule

// File: rtl/mmu_ms_dpath.sv
module mmu_ms_dpath
    import mmu_ms_pkg::*;
(
    input  pstate_t          st,
    input  logic [2:0]       asi,
    input  logic [CTX_W-1:0] sec_ctx,
    output decision_t        dec
);
    logic is_real;
    assign is_real = (asi == AC_REAL);

    always_comb begin
        dec = '0;
        if (asi > AC_REAL) begin
            dec.fault = 1'b1;
        end else if (st.red || (st.hpriv && !is_real)) begin
            dec.mode = XM_BYPASS;
        end else begin
            if (st.tl != '0 || asi == AC_NUC) begin
                dec.kind = CK_NUC;
                dec.ctx  = '0;
            end else if (asi == AC_SEC) begin
                dec.kind = CK_SEC;
                dec.ctx  = sec_ctx;
            end else begin
                dec.kind = CK_PRI;
                dec.ctx  = st.pctx;
            end
            if (!st.dmmu_en || is_real) begin
                dec.mode = XM_REAL;
                dec.ctx  = '0;
            end else begin
                dec.mode = XM_VIRT;
            end
        end
    end
endmodule

// File: rtl/mmu_mode_sel.sv
module mmu_mode_sel
    import mmu_ms_pkg::*;
#(
    parameter int SW_W = 64,
    parameter int VA_W = 48,
    parameter int PA_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_data,
    input  logic [2:0]        req_asi,
    input  logic [SW_W-1:0]   state_word,
    input  logic [CTX_W-1:0]  sec_ctx,
    input  logic [VA_W-1:0]   vaddr,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [1:0]        rsp_mode,
    output logic [1:0]        rsp_kind,
    output logic [CTX_W-1:0]  rsp_ctx,
    output logic [PART_W-1:0] rsp_part,
    output logic [PA_W-1:0]   rsp_paddr
);
    typedef struct packed {
        logic              valid;
        decision_t         dec;
        logic [PART_W-1:0] part;
        logic [PA_W-1:0]   paddr;
    } rsp_t;

    pstate_t   st;
    decision_t dec_i, dec_d_path, dec_sel;
    rsp_t      rsp_d, rsp_q;

    logic unused_va_hi;
    generate
        if (VA_W > PA_W) begin : g_va_wide
            assign unused_va_hi = ^vaddr[VA_W-1:PA_W];
        end else begin : g_va_fit
            assign unused_va_hi = 1'b0;
        end
    endgenerate

    mmu_ms_unpack #(.SW_W(SW_W)) u_unpack (.state_word(state_word), .st(st));
    mmu_ms_ipath u_ipath (.st(st), .asi(req_asi), .dec(dec_i));
    mmu_ms_dpath u_dpath (.st(st), .asi(req_asi), .sec_ctx(sec_ctx), .dec(dec_d_path));

    assign dec_sel = req_is_data ? dec_d_path : dec_i;

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.dec   = dec_sel;
            rsp_d.part  = st.part;
            rsp_d.paddr = (dec_sel.mode == XM_BYPASS) ? vaddr[PA_W-1:0] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_fault = rsp_q.dec.fault;
    assign rsp_mode  = rsp_q.dec.mode;
    assign rsp_kind  = rsp_q.dec.kind;
    assign rsp_ctx   = rsp_q.dec.ctx;
    assign rsp_part  = rsp_q.part;
    assign rsp_paddr = rsp_q.paddr;
endmodule

// File: rtl/mmu_mode_sel_chk.sv
module mmu_mode_sel_chk
    import mmu_ms_pkg::*;
#(
    parameter int VA_W = 48,
    parameter int PA_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_is_data,
    input logic [VA_W-1:0]  vaddr,
    input logic             rsp_valid,
    input logic             rsp_fault,
    input logic [1:0]       rsp_mode,
    input logic [1:0]       rsp_kind,
    input logic [CTX_W-1:0] rsp_ctx,
    input logic [PA_W-1:0]  rsp_paddr
);
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(rsp_mode) && $stable(rsp_ctx) && $stable(rsp_kind)));

    p_fault_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_mode == 2'd0 && rsp_kind == 2'd0
                                      && rsp_ctx == '0 && rsp_paddr == '0));

    p_bypass_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_mode == 2'd2) |-> (rsp_paddr == $past(vaddr[PA_W-1:0]) && rsp_ctx == '0));

    p_real_ctx_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_mode == 2'd1) |-> (rsp_ctx == '0));

    p_nucleus_ctx_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_kind == 2'd2) |-> (rsp_ctx == '0));

    p_secondary_data_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'd1) |-> $past(req_is_data));

    p_paddr_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_mode != 2'd2) |-> (rsp_paddr == '0));
endmodule

bind mmu_mode_sel mmu_mode_sel_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (.*);

// File: tb/mmu_mode_sel_test.sv
module mmu_mode_sel_test;
    localparam int SW_W = 64, VA_W = 48, PA_W = 40, CW = 16, PW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_is_data = 1'b0;
    logic [2:0] req_asi = '0;
    logic [SW_W-1:0] state_word = '0;
    logic [CW-1:0] sec_ctx = '0;
    logic [VA_W-1:0] vaddr = '0;
    logic rsp_valid, rsp_fault;
    logic [1:0] rsp_mode, rsp_kind;
    logic [CW-1:0] rsp_ctx;
    logic [PW-1:0] rsp_part;
    logic [PA_W-1:0] rsp_paddr;

    int checks = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mmu_mode_sel #(.SW_W(SW_W), .VA_W(VA_W), .PA_W(PA_W)) uut (.*);

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [1:0] em, ek, last_m, last_k;
        logic [CW-1:0] ec, pctx, last_c;
        logic ef;
        logic [PA_W-1:0] ep;
        logic [PW-1:0] part;
        logic [2:0] tl;
        string tag;
        last_m = 0; last_k = 0; last_c = 0;
        repeat (3) @(negedge clk);
        check(rsp_valid == 0 && rsp_fault == 0 && rsp_mode == 0 && rsp_ctx == 0 && rsp_paddr == 0,
              "R1", "reset state", {rsp_valid, rsp_fault, rsp_mode, rsp_ctx}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 1024; i++) begin
            bit d, hp, rd, ie, de;
            logic [2:0] a;
            d = i[9]; a = i[8:6]; hp = i[5]; rd = i[4]; ie = i[3]; de = i[2];
            tl = {i[1], i[0], i[1]};
            pctx = 16'h1000 + 16'(i * 7);
            part = 8'(i) ^ 8'h5A;
            req_valid = 1; req_is_data = d; req_asi = a;
            sec_ctx = 16'hA000 ^ 16'(i * 13);
            vaddr = 48'hABCD_0000_0000 ^ 48'(i * 32'h0013_5791);
            state_word = {16'h0, pctx, 13'h0, tl, part, 2'b0, de, ie, 2'b11, rd, hp};
            // expected decision from the requirements
            ef = 0; em = 0; ek = 0; ec = 0; ep = 0;
            if (a > 3'd4 || (!d && a != 3'd0)) begin
                ef = 1; tag = "R3";
            end else if (!d && (hp || rd)) begin
                em = 2; ep = vaddr[PA_W-1:0]; tag = "R4";
            end else if (d && (rd || (hp && a != 3'd4))) begin
                em = 2; ep = vaddr[PA_W-1:0]; tag = "R7";
            end else begin
                if (tl != 0 || (d && a == 3'd3)) begin ek = 2; ec = 0; tag = d ? "R8" : "R5"; end
                else if (d && a == 3'd2) begin ek = 1; ec = sec_ctx; tag = "R9"; end
                else begin ek = 0; ec = pctx; tag = d ? "R9" : "R5"; end
                if ((!d && !ie) || (d && (!de || a == 3'd4))) begin
                    em = 1; ec = 0; tag = d ? "R10" : "R6";
                end
            end
            @(negedge clk);
            check(rsp_valid == 1, "R1", "valid", rsp_valid, 1);
            check(rsp_fault == ef && rsp_mode == em && rsp_kind == ek && rsp_ctx == ec, tag,
                  $sformatf("decision vec %0d", i), {rsp_fault, rsp_mode, rsp_kind, rsp_ctx},
                  {ef, em, ek, ec});
            check(rsp_paddr == ep, (em == 2) ? tag : "R11", "paddr", rsp_paddr, ep);
            check(rsp_part == part, "R2", "partition", rsp_part, part);
            last_m = em; last_k = ek; last_c = ec;
        end
        req_valid = 0;
        @(negedge clk);
        check(rsp_valid == 0 && rsp_mode == last_m && rsp_kind == last_k && rsp_ctx == last_c,
              "R1", "idle hold", {rsp_valid, rsp_mode, rsp_kind, rsp_ctx},
              {1'b0, last_m, last_k, last_c});
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule